// File: doc/BRIEF.md
# Predicated Vector Byte-Load Sequencer

This block carries out one contiguous, predicated load of signed bytes into a vector register of `VLEN` bits. A request is a 32-bit instruction word, the 64-bit base value and the predicate mask. The caller reads the base from the register named in the word, which is the stack pointer when that index is 31. The block decodes the word. It picks a 16-, 32- or 64-bit element size and a signed 4-bit immediate, then visits the elements one at a time, starting at element 0.

For an element whose governing predicate bit is set, the block issues a single-byte read on a valid/ready memory port. It waits for the returned byte and sign-extends it into that element's slot. Elements whose bit is clear are left at zero and cost no memory traffic. The immediate is scaled by the number of elements in the vector, so it steps in whole vector-sized blocks.

When the last element has been handled, `done` pulses for one cycle. The assembled vector and the destination register index are then available. A word that is not one of the three legal forms raises `undef` and starts nothing.

Top module: `vec_byte_load_seq`

## Requirements
- R1: A word is accepted only when bits 31:25 are 1010010, bit 20 is 0, bits 15:13 are 101, and bits 24:21 are 1110 (16-bit elements), 1010 (32-bit) or 1000 (64-bit). Any other word given with `req_valid` while idle pulses `undef` for one cycle in the cycle after the request, issues no read, and leaves `busy` low.
- R2: Element e is read from byte address base + (imm × N + e), where N = VLEN / esize, imm is the two's-complement value of bits 19:16, and all arithmetic is 64-bit modulo 2^64.
- R3: An element whose governing predicate bit is 0 issues no read, and its slot in `result` is all zeros.
- R4: An element whose governing bit is 1 receives the returned byte, sign-extended to the full element width.
- R5: Reads are issued in ascending element order, with at most one outstanding. `rd_addr` is held stable while `rd_valid` is high and `rd_ready` is low, and the next read is not issued before `rsp_valid` has returned the previous byte.
- R6: The predicate holds one bit per vector byte. The governing bit of element e is bit e × (esize / 8).
- R7: If no element is active, the load completes with no read and an all-zero `result`.
- R8: `sp_chk` pulses for one cycle, in the cycle after acceptance, when the base register index (bits 9:5) is 31 and at least one element is active. It stays low otherwise.
- R9: `done` is a one-cycle pulse. At the pulse and afterwards, `result` holds the loaded vector and `dst_idx` holds bits 4:0 of the word, until the next accepted request. A request presented while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `undef`, `sp_chk` and `rd_valid` are low, and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_insn | input | 32 | Instruction word |
| req_base | input | 64 | Base address value (general register or stack pointer) |
| req_pred | input | VLEN/8 | Predicate mask, one bit per vector byte |
| busy | output | 1 | A load is in progress |
| undef | output | 1 | Illegal word pulse |
| sp_chk | output | 1 | Stack-alignment check request pulse |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | 64 | Byte address of the read |
| rd_ready | input | 1 | Memory accepts the read |
| rsp_valid | input | 1 | Read data is valid |
| rsp_data | input | 8 | Returned byte |
| done | output | 1 | Load complete pulse |
| dst_idx | output | 5 | Destination register index |
| result | output | VLEN | Assembled vector |

## Verification
The main function is driven with full, sparse, empty and off-stride predicates at each of the three element sizes. An odd-bit-only mask at 16-bit elements selects no element at all, so it shows whether the governing bit comes from the stride position or from the bit at the element's own index. Immediates of -8, -1, 0, 3, 5 and 7, together with bases near zero and near the top of the address space, show whether the offset is scaled by the element count and whether it wraps in 64 bits. Returned bytes with both sign bit values, a stalled `rd_ready`, and a request overlapping a busy load confirm sign extension, address hold and the ignoring of late requests.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  typedef enum logic [1:0] {ESZ16 = 2'd0, ESZ32 = 2'd1, ESZ64 = 2'd2} esz_e;

  typedef struct packed {
    logic       ok;
    esz_e       esz;
    logic [3:0] imm;
    logic [4:0] rn;
    logic [4:0] rt;
  } dec_t;

  // Field check of the three legal word forms.
  function automatic dec_t decode_word(input logic [31:0] w);
    dec_t d;
    logic fixed;
    fixed = (w[31:25] == 7'b1010010) && !w[20] && (w[15:13] == 3'b101);
    d.imm = w[19:16];
    d.rn  = w[9:5];
    d.rt  = w[4:0];
    d.esz = ESZ16;
    d.ok  = 1'b0;
    case (w[24:21])
      4'b1110: begin d.esz = ESZ16; d.ok = fixed; end
      4'b1010: begin d.esz = ESZ32; d.ok = fixed; end
      4'b1000: begin d.esz = ESZ64; d.ok = fixed; end
      default: d.ok = 1'b0;
    endcase
    return d;
  endfunction

  // log2(esize / 16)
  function automatic logic [1:0] esz_shift(input esz_e e);
    return logic'(e == ESZ32) ? 2'd1 : (e == ESZ64) ? 2'd2 : 2'd0;
  endfunction

  // base + (imm * count + elem), 64-bit wrapping
  function automatic logic [63:0] elem_addr(input logic [63:0] base, input logic [3:0] imm,
                                            input logic [63:0] count, input logic [63:0] elem);
    return base + ({{60{imm[3]}}, imm} * count) + elem;
  endfunction
endpackage

// File: rtl/vbl_decode.sv
module vbl_decode
  import vbl_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int PW = VLEN / 8,
  localparam int NCHUNK = VLEN / 16,
  localparam int EIW = $clog2(NCHUNK + 1)
) (
  input  logic [31:0]    insn,
  input  logic [PW-1:0]  pred,
  output dec_t           dec,
  output logic [1:0]     shift,
  output logic [EIW-1:0] count,
  output logic           any_act
);
  always_comb begin
    int idx;
    dec     = decode_word(insn);
    shift   = esz_shift(dec.esz);
    count   = EIW'(NCHUNK >> shift);
    any_act = 1'b0;
    for (int e = 0; e < NCHUNK; e++) begin
      idx = e << (32'(shift) + 1);
      if (e < int'(count) && idx < PW && pred[idx]) any_act = 1'b1;
    end
  end
endmodule

// File: rtl/vbl_addr_gen.sv
module vbl_addr_gen
  import vbl_pkg::*;
#(
  parameter int EIW = 5
) (
  input  logic [63:0]    base,
  input  logic [3:0]     imm,
  input  logic [EIW-1:0] count,
  input  logic [EIW-1:0] elem,
  output logic [63:0]    addr
);
  assign addr = elem_addr(base, imm, 64'(count), 64'(elem));
endmodule

// File: rtl/vbl_result_pack.sv
module vbl_result_pack #(
  parameter int VLEN = 256,
  localparam int NCHUNK = VLEN / 16,
  localparam int EIW = $clog2(NCHUNK + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr,
  input  logic [1:0]      shift,
  input  logic [EIW-1:0]  elem,
  input  logic [7:0]      data,
  output logic [VLEN-1:0] result
);
  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    logic hit, low;
    assign hit = wr && ((32'(c) >> shift) == 32'(elem));
    assign low = ((32'(c) & ((32'd1 << shift) - 32'd1)) == 32'd0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   result[c*16 +: 16] <= '0;
      else if (clr) result[c*16 +: 16] <= '0;
      else if (hit) result[c*16 +: 16] <= low ? {{8{data[7]}}, data} : {16{data[7]}};
    end
  end

  a_r3_cleared_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> result == '0);
endmodule

// File: rtl/vec_byte_load_seq.sv
module vec_byte_load_seq
  import vbl_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int PW = VLEN / 8,
  localparam int NCHUNK = VLEN / 16,
  localparam int EIW = $clog2(NCHUNK + 1),
  localparam int PIW = $clog2(PW),
  localparam int PXW = PIW + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [31:0]     req_insn,
  input  logic [63:0]     req_base,
  input  logic [PW-1:0]   req_pred,
  output logic            busy,
  output logic            undef,
  output logic            sp_chk,
  output logic            rd_valid,
  output logic [63:0]     rd_addr,
  input  logic            rd_ready,
  input  logic            rsp_valid,
  input  logic [7:0]      rsp_data,
  output logic            done,
  output logic [4:0]      dst_idx,
  output logic [VLEN-1:0] result
);
  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_REQ, S_WAIT, S_FIN} st_e;
  st_e state;

  dec_t           dec;
  logic [1:0]     dec_shift, shift_q;
  logic [EIW-1:0] dec_count, cnt_q, elem_q;
  logic           dec_any;
  logic [3:0]     imm_q;
  logic [63:0]    base_q;
  logic [PW-1:0]  pred_q;

  vbl_decode #(.VLEN(VLEN)) u_dec (
    .insn(req_insn), .pred(req_pred), .dec(dec),
    .shift(dec_shift), .count(dec_count), .any_act(dec_any)
  );

  // Named internal events
  logic           accept, reject, last_pass, elem_act, wait_rsp, lane_wr;
  logic [PXW-1:0] pidx;
  assign accept    = (state == S_IDLE) && req_valid && dec.ok;
  assign reject    = (state == S_IDLE) && req_valid && !dec.ok;
  assign last_pass = (elem_q == cnt_q);
  assign pidx      = PXW'(elem_q) << (32'(shift_q) + 1);
  assign elem_act  = (elem_q < cnt_q) && pred_q[pidx[PIW-1:0]];
  assign wait_rsp  = (state == S_WAIT);
  assign lane_wr   = wait_rsp && rsp_valid;

  vbl_addr_gen #(.EIW(EIW)) u_addr (
    .base(base_q), .imm(imm_q), .count(cnt_q), .elem(elem_q), .addr(rd_addr)
  );

  vbl_result_pack #(.VLEN(VLEN)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(accept), .wr(lane_wr),
    .shift(shift_q), .elem(elem_q), .data(rsp_data), .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      undef   <= 1'b0;
      sp_chk  <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      elem_q  <= '0;
      imm_q   <= '0;
      base_q  <= '0;
      pred_q  <= '0;
      dst_idx <= '0;
    end else begin
      undef  <= reject;
      sp_chk <= accept && (dec.rn == 5'd31) && dec_any;
      case (state)
        S_IDLE: if (accept) begin
          shift_q <= dec_shift;
          cnt_q   <= dec_count;
          elem_q  <= '0;
          imm_q   <= dec.imm;
          base_q  <= req_base;
          pred_q  <= req_pred;
          dst_idx <= dec.rt;
          state   <= S_SCAN;
        end
        S_SCAN: begin
          if (last_pass)     state  <= S_FIN;
          else if (elem_act) state  <= S_REQ;
          else               elem_q <= elem_q + 1'b1;
        end
        S_REQ:  if (rd_ready) state <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          elem_q <= elem_q + 1'b1;
          state  <= S_SCAN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign rd_valid = (state == S_REQ);
  assign done     = (state == S_FIN);

  a_r5_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  a_r3_read_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> elem_act);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_undef_idle: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> !busy);
  a_r8_sp_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    sp_chk |-> $rose(busy));
endmodule

// File: tb/vec_byte_load_seq_tb.sv
module vec_byte_load_seq_tb;
  localparam int VLEN = 256;
  localparam int PW = VLEN / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_insn = '0;
  logic [63:0] req_base = '0;
  logic [PW-1:0] req_pred = '0;
  logic busy, undef, sp_chk, rd_valid, done;
  logic [63:0] rd_addr;
  logic rd_ready = 1'b0, rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;
  logic [4:0] dst_idx;
  logic [VLEN-1:0] result;

  always #5 clk = ~clk;

  vec_byte_load_seq #(.VLEN(VLEN)) u_dut (.*);

  int checks = 0, fails = 0;
  int gnt_delay = 0;
  logic [63:0] log_addr [64];
  int log_n = 0;
  bit addr_moved = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(input logic [63:0] a);
    return a[7:0] ^ {a[3:0], a[7:4]} ^ a[15:8] ^ 8'h93;
  endfunction

  function automatic logic [31:0] mk_insn(input logic [1:0] es, input logic [3:0] imm,
                                          input logic [4:0] rn, input logic [4:0] rt);
    logic [3:0] dt;
    dt = (es == 2'd0) ? 4'b1110 : (es == 2'd1) ? 4'b1010 : 4'b1000;
    return {7'b1010010, dt, 1'b0, imm, 3'b101, 3'd2, rn, rt};
  endfunction

  // Memory model: grants after gnt_delay stalled cycles, answers one cycle after the grant.
  initial begin
    bit pend = 1'b0, stalled = 1'b0;
    logic [63:0] paddr = '0, last = '0;
    int sc = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (pend) begin rsp_valid = 1'b1; rsp_data = memf(paddr); pend = 1'b0; end
      if (rd_valid) begin
        if (stalled && rd_addr != last) addr_moved = 1'b1;
        last = rd_addr;
        if (sc >= gnt_delay) begin
          rd_ready = 1'b1; pend = 1'b1; paddr = rd_addr;
          if (log_n < 64) log_addr[log_n] = rd_addr;
          log_n++; sc = 0; stalled = 1'b0;
        end else begin
          rd_ready = 1'b0; sc++; stalled = 1'b1;
        end
      end else begin
        rd_ready = 1'b0; sc = 0; stalled = 1'b0;
      end
    end
  end

  task automatic run_load(input logic [1:0] es, input logic [3:0] imm, input logic [4:0] rn,
                          input logic [4:0] rt, input logic [31:0] pred, input logic [63:0] base,
                          input bit poke_busy, input string tag);
    int esz, n, nexp, w;
    logic [255:0] exp;
    logic [63:0] ea [64];
    logic [63:0] a;
    logic [7:0] b;
    bit any;
    esz = 16 << es; n = VLEN / esz; nexp = 0; exp = '0; any = 1'b0;
    for (int e = 0; e < n; e++) begin
      if (pred[e * (esz / 8)]) begin                // R6 stride position
        a = base + ({{60{imm[3]}}, imm} * 64'(n)) + 64'(e);   // R2
        ea[nexp] = a; nexp++; any = 1'b1;
        b = memf(a);
        for (int k = 0; k < esz; k++) exp[e * esz + k] = (k < 8) ? b[k] : b[7];  // R4
      end
    end
    log_n = 0; addr_moved = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_insn = mk_insn(es, imm, rn, rt); req_base = base; req_pred = pred;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, {"R9 busy after start ", tag}, 256'(busy), 256'(1));
    chk(sp_chk == (rn == 5'd31 && any), {"R8 sp_chk ", tag}, 256'(sp_chk), 256'(rn == 5'd31 && any));
    if (poke_busy) begin
      @(negedge clk);
      req_valid = 1'b1; req_insn = mk_insn(2'd0, 4'd1, 5'd1, 5'd9); req_base = 64'hDEAD00; req_pred = '1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    chk(done == 1'b1, {"R9 done reached ", tag}, 256'(done), 256'(1));
    chk(result == exp, {"R3 R4 result ", tag}, result, exp);
    chk(dst_idx == rt, {"R9 dst_idx ", tag}, 256'(dst_idx), 256'(rt));
    chk(log_n == nexp, {"R3 R7 read count ", tag}, 256'(log_n), 256'(nexp));
    for (int i = 0; i < nexp && i < log_n; i++)
      chk(log_addr[i] == ea[i], {"R2 R5 read address ", tag}, 256'(log_addr[i]), 256'(ea[i]));
    chk(!addr_moved, {"R5 address held in stall ", tag}, 256'(addr_moved), 256'(0));
    @(negedge clk);
    chk(!done && result == exp, {"R9 pulse and hold ", tag}, 256'(done), 256'(0));
  endtask

  localparam int NV = 8;
  localparam logic [1:0]  T_ES   [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0, 2'd2, 2'd1};
  localparam logic [3:0]  T_IMM  [NV] = '{4'h0, 4'hF, 4'h7, 4'h8, 4'h3, 4'h5, 4'h8, 4'h0};
  localparam logic [4:0]  T_RN   [NV] = '{5'd3, 5'd31, 5'd5, 5'd31, 5'd7, 5'd0, 5'd31, 5'd31};
  localparam logic [31:0] T_PRED [NV] = '{32'hFFFF_FFFF, 32'h1111_1111, 32'h0000_0101, 32'hAAAA_AAAA,
                                          32'h0F0F_00F1, 32'h5555_0001, 32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic [63:0] T_BASE [NV] = '{64'h1000, 64'h2000_0040, 64'h10, 64'h300,
                                          64'hFFFF_FFFF_FFFF_FFF0, 64'h7F80, 64'h5, 64'h40};

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, done, undef, sp_chk, rd_valid} == 5'b0, "R10 control outputs in reset",
        256'({busy, done, undef, sp_chk, rd_valid}), 256'(0));
    chk(result == '0, "R10 result in reset", result, 256'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R6 R7 R8 table walk (vector 3: odd bits only, none governing)
    for (int i = 0; i < NV; i++)
      run_load(T_ES[i], T_IMM[i], T_RN[i], 5'(i + 4), T_PRED[i], T_BASE[i], 1'b0, $sformatf("vec%0d", i));

    // R5 stalled ready
    gnt_delay = 3;
    run_load(2'd2, 4'h2, 5'd31, 5'd30, 32'h0101_0001, 64'h8000, 1'b0, "stall");
    gnt_delay = 0;

    // R9 request while busy is ignored
    run_load(2'd1, 4'h6, 5'd2, 5'd17, 32'h0000_F0F1, 64'h1234, 1'b1, "busy_poke");

    // R1 illegal words: bit 20 set, then a bad size field
    for (int j = 0; j < 2; j++) begin
      log_n = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_insn = (j == 0) ? (mk_insn(2'd0, 4'd0, 5'd1, 5'd1) | 32'h0010_0000)
                          : {7'b1010010, 4'b1100, 1'b0, 4'd0, 3'b101, 3'd0, 5'd1, 5'd1};
      req_pred = '1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(undef && !busy, $sformatf("R1 undef pulse word%0d", j), 256'({undef, busy}), 256'(2'b10));
      repeat (4) @(negedge clk);
      chk(!undef && !busy && log_n == 0, $sformatf("R1 no load after undef word%0d", j),
          256'({undef, busy, 8'(log_n)}), 256'(0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule